// File: doc/BRIEF.md
# Configurable Logic Cell with Carry and Cascade

This block is one logic cell of a programmable fabric. It has a four-input lookup table, one flip-flop, a carry path and a cascade path. Its function is fixed by parameters: the table contents, the source chosen for each of its two outputs, the data source of the flip-flop, logic or arithmetic mode, and whether the cascade path is used with AND or OR combining. Adjacent cells are wired cin-to-cout and cas_in-to-cas_out to build adders, accumulators and wide comparators.

Each output picks, on its own, the table result or the flip-flop. This lets the two parts serve unrelated functions (packing, with the flip-flop loaded from a dedicated input). It also lets a cell present the registered and unregistered forms of one result together. In arithmetic mode the table splits into a sum half and a carry half, and carry-in feeds both.

Top module: `lcell_elem`

## Requirements
- R1: In logic mode, the table result is the bit of LUT_MASK at index {d[3],d[2],d[1],d[0]}, with d[0] as the index LSB. It appears in the same cycle on every output whose source parameter is 0 (table).
- R2: Each output has its own source parameter: 0 selects the table result, 1 selects the flip-flop. With the flip-flop fed from the table, one output shows the present result while the other shows the value captured at the last loading edge.
- R3: With REG_SRC set to 1 (direct), the flip-flop loads reg_direct and the table-side output is unaffected by reg_direct.
- R4: rst_n low clears the flip-flop to 0 at once. At a rising edge, sclr high loads 0 whatever ce is. ce low with sclr low holds the value. ce high with sclr low loads the data.
- R5: In arithmetic mode, let k = {cin,d[1],d[0]} (cin as MSB). The sum is LUT_MASK[8+k] and cout is LUT_MASK[k]. d[2] and d[3] have no effect.
- R6: In logic mode, cout is 0 whatever the values of cin and d.
- R7: n arithmetic cells with mask 16'h96E8 on a carry chain, followed by one arithmetic cell with mask 16'hF000, give the n+1-bit sum a+b+cin. The last cell's table output carries the top bit.
- R8: Arithmetic cells with mask 16'h96E8, the flip-flop on the sum, its output fed back to d[1] and the addend on d[0] form an accumulator. Each loading edge adds the addend modulo 2^n, and sclr returns it to 0.
- R9: With the cascade on, the cell result is table AND cas_in (op 0) or table OR cas_in (op 1). This result drives cas_out and the table-side outputs. The identity input is 1 for AND and 0 for OR. With the cascade off, cas_in has no effect.
- R10: Eight AND-cascaded cells with mask 16'h9009 on inputs {b[2i+1],a[2i+1],b[2i],a[2i]} produce a==b from a 16-bit pair. With mask 16'h6FF6 and OR combining, they produce a!=b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| ce | input | 1 | Clock enable of the flip-flop |
| sclr | input | 1 | Synchronous clear, overrides ce |
| d | input | LUT_INPUTS | Table inputs; d[0], d[1] are the operands in arithmetic mode |
| reg_direct | input | 1 | Flip-flop data when packing is selected |
| cin | input | 1 | Carry from the lower-order cell |
| cas_in | input | 1 | Cascade value from the previous cell |
| out_a | output | 1 | First routing output |
| out_b | output | 1 | Second routing output |
| cout | output | 1 | Carry to the higher-order cell |
| cas_out | output | 1 | Cascade value to the next cell |

## Verification
The two functions that share a cycle are the table evaluation on one output and the flip-flop update on the other. In a packed cell these work on unrelated data. In a registered-and-unregistered cell they work on the same result. The bench changes d, reg_direct, ce and sclr all together on every cycle. For the same cycle it queues the expected table output. For the next cycle it queues the expected flip-flop output, including cycles where sclr and ce are both high. A monitor judges each queued item when it falls due.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

   typedef enum logic {
      SRC_LUT = 1'b0,
      SRC_REG = 1'b1
   } out_src_e;

   typedef enum logic {
      FN_LOGIC = 1'b0,
      FN_ARITH = 1'b1
   } fn_mode_e;

   typedef enum logic {
      RIN_LUT    = 1'b0,
      RIN_DIRECT = 1'b1
   } reg_src_e;

   typedef enum logic {
      CASC_AND = 1'b0,
      CASC_OR  = 1'b1
   } casc_op_e;

   function automatic logic casc_identity(casc_op_e op);
      return (op == CASC_AND);
   endfunction

endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
   parameter int                         N_IN    = 4,
   parameter logic [(1<<N_IN)-1:0]       MASK    = '0,
   parameter lcell_pkg::fn_mode_e        FN_MODE = lcell_pkg::FN_LOGIC
) (
   input  logic [N_IN-1:0] d,
   input  logic            cin,
   output logic            lut_o,
   output logic            carry_o
);
   import lcell_pkg::*;

   localparam int DEPTH = 1 << N_IN;
   localparam int HALF  = DEPTH / 2;

   generate
      if (FN_MODE == FN_ARITH) begin : g_arith
         logic [N_IN-1:0] sum_idx;
         logic [N_IN-1:0] cy_idx;
         logic            hi_unused;

         // cin takes the place of d[2]; the top index bit picks the half
         always_comb begin
            sum_idx          = '0;
            sum_idx[2:0]     = {cin, d[1], d[0]};
            sum_idx[N_IN-1]  = 1'b1;
            cy_idx           = sum_idx;
            cy_idx[N_IN-1]   = 1'b0;
         end

         assign lut_o     = MASK[sum_idx];
         assign carry_o   = MASK[cy_idx];
         assign hi_unused = ^d[N_IN-1:2];

         if (HALF < 8) begin : g_small
            $error("lcell_lut: arithmetic mode needs at least four inputs");
         end
      end else begin : g_logic
         logic cin_unused;
         assign lut_o      = MASK[d];
         assign carry_o    = 1'b0;
         assign cin_unused = cin;
      end
   endgenerate

endmodule

// File: rtl/lcell_cascade.sv
module lcell_cascade #(
   parameter bit                  CASC_EN = 1'b0,
   parameter lcell_pkg::casc_op_e CASC_OP = lcell_pkg::CASC_AND
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lut_i,
   input  logic cas_in,
   output logic res_o
);
   import lcell_pkg::*;

   generate
      if (!CASC_EN) begin : g_off
         logic in_unused;
         assign res_o     = lut_i;
         assign in_unused = cas_in ^ clk ^ rst_n;
      end else if (CASC_OP == CASC_AND) begin : g_and
         assign res_o = lut_i & cas_in;

         // R9
         cas_and_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cas_in |-> !res_o);
      end else begin : g_or
         assign res_o = lut_i | cas_in;

         // R9
         cas_or_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cas_in |-> res_o);
      end
   endgenerate

endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic ce,
   input  logic sclr,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (sclr) begin
         q <= 1'b0;
      end else if (ce) begin
         q <= d;
      end
   end

   // R4
   sclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclr |=> (q == 1'b0));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && !ce) |=> $stable(q));

   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && ce) |=> (q == $past(d)));

endmodule

// File: rtl/lcell_elem.sv
module lcell_elem #(
   parameter int                              LUT_INPUTS = 4,
   parameter logic [(1<<LUT_INPUTS)-1:0]      LUT_MASK   = '0,
   parameter lcell_pkg::fn_mode_e             FN_MODE    = lcell_pkg::FN_LOGIC,
   parameter lcell_pkg::out_src_e             OUT_A_SRC  = lcell_pkg::SRC_LUT,
   parameter lcell_pkg::out_src_e             OUT_B_SRC  = lcell_pkg::SRC_REG,
   parameter lcell_pkg::reg_src_e             REG_SRC    = lcell_pkg::RIN_LUT,
   parameter bit                              CASC_EN    = 1'b0,
   parameter lcell_pkg::casc_op_e             CASC_OP    = lcell_pkg::CASC_AND
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce,
   input  logic                  sclr,
   input  logic [LUT_INPUTS-1:0] d,
   input  logic                  reg_direct,
   input  logic                  cin,
   input  logic                  cas_in,
   output logic                  out_a,
   output logic                  out_b,
   output logic                  cout,
   output logic                  cas_out
);
   import lcell_pkg::*;

   localparam bit SPLIT_OUT = (OUT_A_SRC != OUT_B_SRC);

   generate
      if (LUT_INPUTS < 2 || LUT_INPUTS > 6) begin : g_bad_width
         $error("lcell_elem: LUT_INPUTS must lie in 2..6");
      end
      if (FN_MODE == FN_ARITH && CASC_EN) begin : g_bad_combo
         $error("lcell_elem: cascade cannot be used in arithmetic mode");
      end
      if (FN_MODE == FN_ARITH && LUT_INPUTS < 4) begin : g_bad_arith
         $error("lcell_elem: arithmetic mode needs LUT_INPUTS >= 4");
      end
   endgenerate

   logic lut_v;
   logic carry_v;
   logic comb_v;
   logic ff_d;
   logic ff_q;

   lcell_lut #(
      .N_IN    (LUT_INPUTS),
      .MASK    (LUT_MASK),
      .FN_MODE (FN_MODE)
   ) u_lut (
      .d       (d),
      .cin     (cin),
      .lut_o   (lut_v),
      .carry_o (carry_v)
   );

   lcell_cascade #(
      .CASC_EN (CASC_EN),
      .CASC_OP (CASC_OP)
   ) u_cas (
      .clk    (clk),
      .rst_n  (rst_n),
      .lut_i  (lut_v),
      .cas_in (cas_in),
      .res_o  (comb_v)
   );

   assign cas_out = comb_v;
   assign cout    = carry_v;

   generate
      if (REG_SRC == RIN_DIRECT) begin : g_pack
         assign ff_d = reg_direct;
      end else begin : g_from_lut
         logic direct_unused;
         assign ff_d          = comb_v;
         assign direct_unused = reg_direct;
      end
   endgenerate

   lcell_ff u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .sclr  (sclr),
      .d     (ff_d),
      .q     (ff_q)
   );

   generate
      if (OUT_A_SRC == SRC_REG) begin : g_a_reg
         assign out_a = ff_q;
      end else begin : g_a_lut
         assign out_a = comb_v;
      end

      if (OUT_B_SRC == SRC_REG) begin : g_b_reg
         assign out_b = ff_q;
      end else begin : g_b_lut
         assign out_b = comb_v;
      end

      if (SPLIT_OUT) begin : g_split_chk
         logic lut_side;
         logic reg_side;
         assign lut_side = (OUT_A_SRC == SRC_LUT) ? out_a : out_b;
         assign reg_side = (OUT_A_SRC == SRC_LUT) ? out_b : out_a;

         if (REG_SRC == RIN_LUT) begin : g_same
            // R2
            reg_trails_lut_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (ce && !sclr) |=> (reg_side == $past(lut_side)));
         end else begin : g_packed
            // R3
            packed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (ce && !sclr) |=> (reg_side == $past(reg_direct)));
         end
      end
   endgenerate

endmodule

// File: tb/lcell_elem_test.sv
`timescale 1ns/1ps
module lcell_elem_test;
   import lcell_pkg::*;

   localparam logic [15:0] DUAL_MASK = 16'hB4E1;
   localparam int K_UA = 0, K_UB = 1, K_UCOUT = 2, K_DA = 3, K_DB = 4,
                  K_SUM = 5, K_ACC = 6, K_EQ = 7, K_NE = 8;

   typedef struct {
      int          kind;
      logic [15:0] exp;
      int          due;
      string       req;
   } sb_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   sb_item_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // packed cell: out_a = table (4-input parity), out_b = flip-flop from reg_direct
   logic [3:0] u_d = '0;
   logic u_dir = 0, u_ce = 0, u_sclr = 0, u_cin = 0, u_cas = 0;
   logic u_a, u_b, u_cout, u_casout;

   lcell_elem #(.LUT_MASK(16'h6996), .OUT_A_SRC(SRC_LUT), .OUT_B_SRC(SRC_REG),
                .REG_SRC(RIN_DIRECT)) uut (
      .clk(clk), .rst_n(rst_n), .ce(u_ce), .sclr(u_sclr), .d(u_d),
      .reg_direct(u_dir), .cin(u_cin), .cas_in(u_cas),
      .out_a(u_a), .out_b(u_b), .cout(u_cout), .cas_out(u_casout));

   // dual cell: out_a = registered table result, out_b = unregistered
   logic [3:0] dl_d = '0;
   logic dl_ce = 0, dl_sclr = 0;
   logic dl_a, dl_b, dl_cout, dl_casout;

   lcell_elem #(.LUT_MASK(DUAL_MASK), .OUT_A_SRC(SRC_REG), .OUT_B_SRC(SRC_LUT),
                .REG_SRC(RIN_LUT)) u_dual (
      .clk(clk), .rst_n(rst_n), .ce(dl_ce), .sclr(dl_sclr), .d(dl_d),
      .reg_direct(1'b0), .cin(1'b0), .cas_in(1'b1),
      .out_a(dl_a), .out_b(dl_b), .cout(dl_cout), .cas_out(dl_casout));

   // 8-bit ripple adder: 8 sum cells plus a final carry cell
   logic [7:0]  add_a = '0, add_b = '0;
   logic        add_cin = 0;
   logic [17:0] add_junk = '0;
   logic [8:0]  add_c;
   logic [7:0]  add_s;
   logic [8:0]  add_ob, add_cas;
   logic        add_fin, add_fc;
   assign add_c[0] = add_cin;

   for (genvar i = 0; i < 8; i++) begin : g_add
      lcell_elem #(.LUT_MASK(16'h96E8), .FN_MODE(FN_ARITH)) u_bit (
         .clk(clk), .rst_n(rst_n), .ce(1'b0), .sclr(1'b0),
         .d({add_junk[2*i+1], add_junk[2*i], add_b[i], add_a[i]}),
         .reg_direct(1'b0), .cin(add_c[i]), .cas_in(1'b0),
         .out_a(add_s[i]), .out_b(add_ob[i]), .cout(add_c[i+1]), .cas_out(add_cas[i]));
   end

   lcell_elem #(.LUT_MASK(16'hF000), .FN_MODE(FN_ARITH)) u_add_last (
      .clk(clk), .rst_n(rst_n), .ce(1'b0), .sclr(1'b0),
      .d({add_junk[17], add_junk[16], 2'b00}), .reg_direct(1'b0),
      .cin(add_c[8]), .cas_in(1'b0),
      .out_a(add_fin), .out_b(add_ob[8]), .cout(add_fc), .cas_out(add_cas[8]));

   // 8-bit accumulator
   logic [7:0] acc_in = '0;
   logic       acc_ce = 0, acc_sclr = 0;
   logic [7:0] acc_q, acc_ob, acc_cas;
   logic [8:0] acc_c;
   assign acc_c[0] = 1'b0;

   for (genvar i = 0; i < 8; i++) begin : g_acc
      lcell_elem #(.LUT_MASK(16'h96E8), .FN_MODE(FN_ARITH), .OUT_A_SRC(SRC_REG),
                   .OUT_B_SRC(SRC_LUT), .REG_SRC(RIN_LUT)) u_bit (
         .clk(clk), .rst_n(rst_n), .ce(acc_ce), .sclr(acc_sclr),
         .d({2'b00, acc_q[i], acc_in[i]}), .reg_direct(1'b0),
         .cin(acc_c[i]), .cas_in(1'b0),
         .out_a(acc_q[i]), .out_b(acc_ob[i]), .cout(acc_c[i+1]), .cas_out(acc_cas[i]));
   end

   // 16-bit comparators: equality (AND chain) and inequality (OR chain)
   logic [15:0] cmp_a = '0, cmp_b = '0;
   logic        eq_seed = 1, ne_seed = 0;
   logic [8:0]  eq_ch, ne_ch;
   logic [7:0]  eq_oa, eq_ob, eq_co, ne_oa, ne_ob, ne_co;
   assign eq_ch[0] = eq_seed;
   assign ne_ch[0] = ne_seed;

   for (genvar i = 0; i < 8; i++) begin : g_cmp
      lcell_elem #(.LUT_MASK(16'h9009), .CASC_EN(1'b1), .CASC_OP(CASC_AND)) u_eq (
         .clk(clk), .rst_n(rst_n), .ce(1'b0), .sclr(1'b0),
         .d({cmp_b[2*i+1], cmp_a[2*i+1], cmp_b[2*i], cmp_a[2*i]}),
         .reg_direct(1'b0), .cin(1'b0), .cas_in(eq_ch[i]),
         .out_a(eq_oa[i]), .out_b(eq_ob[i]), .cout(eq_co[i]), .cas_out(eq_ch[i+1]));
      lcell_elem #(.LUT_MASK(16'h6FF6), .CASC_EN(1'b1), .CASC_OP(CASC_OR)) u_ne (
         .clk(clk), .rst_n(rst_n), .ce(1'b0), .sclr(1'b0),
         .d({cmp_b[2*i+1], cmp_a[2*i+1], cmp_b[2*i], cmp_a[2*i]}),
         .reg_direct(1'b0), .cin(1'b0), .cas_in(ne_ch[i]),
         .out_a(ne_oa[i]), .out_b(ne_ob[i]), .cout(ne_co[i]), .cas_out(ne_ch[i+1]));
   end

   function automatic logic [15:0] actual(int k);
      case (k)
         K_UA:    return {15'd0, u_a};
         K_UB:    return {15'd0, u_b};
         K_UCOUT: return {15'd0, u_cout};
         K_DA:    return {15'd0, dl_a};
         K_DB:    return {15'd0, dl_b};
         K_SUM:   return {7'd0, add_fin, add_s};
         K_ACC:   return {8'd0, acc_q};
         K_EQ:    return {15'd0, eq_ch[8]};
         K_NE:    return {15'd0, ne_ch[8]};
         default: return 16'hDEAD;
      endcase
   endfunction

   task automatic push(int kind, logic [15:0] exp, int delay, string req);
      sb_item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.due  = cyc + delay;
      it.req  = req;
      sb.push_back(it);
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: judges every queued item in the cycle it falls due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         sb_item_t it;
         it = sb.pop_front();
         chk(it.req, actual(it.kind), it.exp);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   logic       u_q_m = 0, dl_q_m = 0;
   logic [7:0] acc_m = 0;

   task automatic drive_mixed(logic [3:0] ud, logic dir, logic uce, logic usclr,
                              logic [3:0] dd, logic dce, logic dsclr);
      logic lut_d;
      tick();
      u_d = ud; u_dir = dir; u_ce = uce; u_sclr = usclr;
      u_cin = 1'($urandom); u_cas = 1'($urandom);
      dl_d = dd; dl_ce = dce; dl_sclr = dsclr;
      lut_d = DUAL_MASK[dd];
      push(K_UA, {15'd0, ^ud}, 0, "R1/R3/R9 table side of packed cell");
      push(K_UCOUT, 16'd0, 0, "R6 cout in logic mode");
      push(K_DB, {15'd0, lut_d}, 0, "R1/R2 unregistered output");
      u_q_m  = usclr ? 1'b0 : (uce ? dir : u_q_m);
      dl_q_m = dsclr ? 1'b0 : (dce ? lut_d : dl_q_m);
      push(K_UB, {15'd0, u_q_m}, 1, "R3/R4 packed register");
      push(K_DA, {15'd0, dl_q_m}, 1, "R2/R4 registered output");
   endtask

   task automatic drive_add(logic [7:0] a, logic [7:0] b, logic c);
      logic [8:0] s;
      tick();
      add_a = a; add_b = b; add_cin = c; add_junk = 18'($urandom);
      s = 9'(a) + 9'(b) + 9'(c);
      push(K_SUM, {7'd0, s}, 0, "R5/R7 ripple adder");
   endtask

   task automatic drive_cmp(logic [15:0] a, logic [15:0] b, logic es, logic ns);
      tick();
      cmp_a = a; cmp_b = b; eq_seed = es; ne_seed = ns;
      push(K_EQ, {15'd0, (a == b) & es}, 0, "R9/R10 equality chain");
      push(K_NE, {15'd0, (a != b) | ns}, 0, "R9/R10 inequality chain");
   endtask

   task automatic drive_acc(logic [7:0] v, logic ce, logic sc);
      tick();
      acc_in = v; acc_ce = ce; acc_sclr = sc;
      acc_m = sc ? 8'd0 : (ce ? acc_m + v : acc_m);
      push(K_ACC, {8'd0, acc_m}, 1, "R8 accumulator");
   endtask

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      u_dir = 1; u_ce = 1; dl_ce = 1; acc_ce = 1;
      u_d = 4'hF; dl_d = 4'hF; acc_in = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4: reset holds every flip-flop at zero despite enabled loads
      chk("R4 reset packed reg", {15'd0, u_b}, 16'd0);
      chk("R4 reset dual reg", {15'd0, dl_a}, 16'd0);
      chk("R4 reset accumulator", {8'd0, acc_q}, 16'd0);
      @(posedge clk);
      #1;
      rst_n = 1;
      u_ce = 0; dl_ce = 0; acc_ce = 0;

      // R1 R2 R3 R4 R6 R9: table and flip-flop active together
      for (int i = 0; i < 80; i++) begin
         drive_mixed(4'($urandom), 1'($urandom), ($urandom % 4) != 0,
                     ($urandom % 5) == 0, 4'($urandom), ($urandom % 4) != 0,
                     ($urandom % 5) == 0);
      end
      // sclr and ce high together, then ce low holding a loaded one
      drive_mixed(4'h0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0);
      drive_mixed(4'h1, 1'b1, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1);
      drive_mixed(4'h3, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0);
      drive_mixed(4'h7, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0);
      drive_mixed(4'hF, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 1'b0);

      // R5 R7: adder corners and random operands
      drive_add(8'h00, 8'h00, 1'b0);
      drive_add(8'hFF, 8'h01, 1'b0);
      drive_add(8'hFF, 8'hFF, 1'b1);
      drive_add(8'hFF, 8'h00, 1'b1);
      for (int i = 0; i < 60; i++) drive_add(8'($urandom), 8'($urandom), 1'($urandom));

      // R9 R10: comparator matches, single-bit misses, non-identity seeds
      drive_cmp(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
      drive_cmp(16'h0000, 16'h8000, 1'b1, 1'b0);
      drive_cmp(16'h1234, 16'h1234, 1'b0, 1'b1);
      for (int i = 0; i < 60; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         a = 16'($urandom);
         b = (($urandom % 2) == 0) ? a : (a ^ (16'd1 << ($urandom % 16)));
         drive_cmp(a, b, ($urandom % 8) != 0, ($urandom % 8) == 0);
      end

      // R8: accumulator clear, wrap, hold, random
      drive_acc(8'd0, 1'b0, 1'b1);
      drive_acc(8'd200, 1'b1, 1'b0);
      drive_acc(8'd100, 1'b1, 1'b0);
      drive_acc(8'd55, 1'b0, 1'b0);
      drive_acc(8'd9, 1'b1, 1'b1);
      for (int i = 0; i < 60; i++)
         drive_acc(8'($urandom), ($urandom % 4) != 0, ($urandom % 16) == 0);

      repeat (3) tick();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule